// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry-Out

This block shifts or rotates a 32-bit data word by an amount taken from an 8-bit field, so the amount can be anything from 0 to 255. Four operations are offered: logical left, logical right, arithmetic right and rotate right. Alongside the shifted word it returns the new carry, following exact rules for the awkward amounts: zero, exactly the word width, and beyond the word width. The caller passes the low byte of its amount register as `in_amt`.

The datapath is combinational and is followed by one output register stage. A small two-state machine tracks whether that stage holds a fresh result. `ST_EMPTY` moves to `ST_LOADED` on a cycle with `in_valid` high (transition LOAD). `ST_LOADED` stays in `ST_LOADED` on another valid cycle (transition RELOAD) and returns to `ST_EMPTY` when `in_valid` is low (transition DRAIN). `out_valid` is high exactly in `ST_LOADED`. Result and carry registers load only on valid cycles and otherwise keep their value.

Top module: `regshift_unit`

## Requirements
- R1: An amount of 0 returns the data word unchanged and the carry equal to `in_carry`, for every operation.
- R2: Logical left (`in_kind` = 0) by n in 1..31 returns the data shifted left with zero fill, and the carry equals data bit (32 − n).
- R3: Logical left by exactly 32 returns 0 with carry equal to data bit 0; logical left or logical right by 33..255 returns 0 with carry 0.
- R4: Logical right (`in_kind` = 1) by n in 1..31 returns the data shifted right with zero fill and carry equal to data bit (n − 1); by exactly 32 it returns 0 with carry equal to data bit 31.
- R5: Arithmetic right (`in_kind` = 2) by n in 1..31 fills from the sign bit with carry equal to data bit (n − 1); by 32..255 every result bit and the carry equal data bit 31.
- R6: Rotate right (`in_kind` = 3) reduces the amount modulo 32; when the reduced amount is 0 but the amount is not, the data is unchanged and the carry equals data bit 31.
- R7: Rotate right by a non-zero reduced amount r rotates the data right by r and gives carry equal to data bit (r − 1).
- R8: A result presented with `in_valid` high appears on `out_data`/`out_carry` with `out_valid` high after exactly one rising clock edge.
- R9: After a clock edge with `in_valid` low, `out_valid` is low and `out_data`/`out_carry` keep their previous values, whatever the other inputs are.
- R10: While `rst_n` is low and after its release, `out_valid`, `out_data` and `out_carry` are 0 until the first valid input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operands are present this cycle |
| in_data | input | 32 | Data word to shift |
| in_amt | input | 8 | Shift amount, unsigned 0..255 |
| in_kind | input | 2 | Operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| in_carry | input | 1 | Current carry, returned for amount 0 |
| out_valid | output | 1 | Registered result is fresh |
| out_data | output | 32 | Shifted or rotated word |
| out_carry | output | 1 | New carry |

## Verification
The zero-amount pass-through and the width-multiple cases meet in one cycle whenever the amount's low five bits are zero: amount 0 must return the incoming carry, while 32, 64, 96 and so on must take their carry from the data or force it to 0, depending on the operation. The bench provokes this by sweeping every amount 0..255 for each operation with the carry input toggling, and judges each output against a per-bit model built from the requirements. It also pairs the output register's hold behaviour with a changed input, dropping `in_valid` while data and amount move, to check that the hold wins over the new operands.

// File: rtl/regshift_pkg.sv
package regshift_pkg;

    typedef enum logic [1:0] {
        KIND_LSL = 2'd0,
        KIND_LSR = 2'd1,
        KIND_ASR = 2'd2,
        KIND_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } stage_state_e;

endpackage

// File: rtl/regshift_left.sv
module regshift_left #(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     d_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             c_i,
    output logic [W-1:0]     res_o,
    output logic             c_o
);
    // One guard bit above the word catches the last bit shifted out.
    logic [W:0] ext;

    always_comb begin
        ext = {1'b0, d_i} << amt_i;
        if (amt_i == '0) begin
            res_o = d_i;
            c_o   = c_i;
        end else begin
            res_o = ext[W-1:0];
            c_o   = ext[W];
        end
    end
endmodule

// File: rtl/regshift_right.sv
module regshift_right #(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     d_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             arith_i,
    input  logic             c_i,
    output logic [W-1:0]     res_o,
    output logic             c_o
);
    // One guard bit below the word catches the last bit shifted out.
    logic        [W:0] ext_l;
    logic signed [W:0] ext_a;
    logic        [W:0] ext;

    always_comb begin
        ext_l = {d_i, 1'b0} >> amt_i;
        ext_a = $signed({d_i, 1'b0}) >>> amt_i;
        ext   = arith_i ? ext_a : ext_l;
        if (amt_i == '0) begin
            res_o = d_i;
            c_o   = c_i;
        end else begin
            res_o = ext[W:1];
            c_o   = ext[0];
        end
    end
endmodule

// File: rtl/regshift_rotate.sv
module regshift_rotate #(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     d_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             c_i,
    output logic [W-1:0]     res_o,
    output logic             c_o
);
    localparam int RW = $clog2(W);

    logic [RW-1:0] red;
    logic [W-1:0]  rot;

    always_comb begin
        red = amt_i[RW-1:0];
        // A reduced amount of zero makes the left term vanish and returns d_i.
        rot = (d_i >> red) | (d_i << (W - int'(red)));
        if (amt_i == '0) begin
            res_o = d_i;
            c_o   = c_i;
        end else begin
            res_o = rot;
            c_o   = rot[W-1];
        end
    end
endmodule

// File: rtl/regshift_unit.sv
module regshift_unit
    import regshift_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     in_data,
    input  logic [AMT_W-1:0] in_amt,
    input  logic [1:0]       in_kind,
    input  logic             in_carry,
    output logic             out_valid,
    output logic [W-1:0]     out_data,
    output logic             out_carry
);
    localparam int RW = $clog2(W);

    shift_kind_e  kind;
    stage_state_e state_q, state_d;

    logic [W-1:0] lsl_res, rsh_res, ror_res, sel_res;
    logic         lsl_c,   rsh_c,   ror_c,   sel_c;

    assign kind = shift_kind_e'(in_kind);

    regshift_left #(.W(W), .AMT_W(AMT_W)) u_left (
        .d_i(in_data), .amt_i(in_amt), .c_i(in_carry),
        .res_o(lsl_res), .c_o(lsl_c)
    );

    regshift_right #(.W(W), .AMT_W(AMT_W)) u_right (
        .d_i(in_data), .amt_i(in_amt), .arith_i(kind == KIND_ASR),
        .c_i(in_carry), .res_o(rsh_res), .c_o(rsh_c)
    );

    regshift_rotate #(.W(W), .AMT_W(AMT_W)) u_rotate (
        .d_i(in_data), .amt_i(in_amt), .c_i(in_carry),
        .res_o(ror_res), .c_o(ror_c)
    );

    always_comb begin
        unique case (kind)
            KIND_LSL: begin sel_res = lsl_res; sel_c = lsl_c; end
            KIND_LSR,
            KIND_ASR: begin sel_res = rsh_res; sel_c = rsh_c; end
            KIND_ROR: begin sel_res = ror_res; sel_c = ror_c; end
            default:  begin sel_res = lsl_res; sel_c = lsl_c; end
        endcase
    end

    // Next-state logic: LOAD, RELOAD, DRAIN.
    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_carry <= 1'b0;
        end else if (in_valid) begin
            out_data  <= sel_res;
            out_carry <= sel_c;
        end
    end

    assign out_valid = (state_q == ST_LOADED);

    // R8: a valid input yields a valid output on the next cycle
    a_r8_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: idle cycle holds the registered result
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_carry)));

    // R1: zero amount passes data and carry through
    a_r1_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_amt == '0) |=>
            (out_data == $past(in_data) && out_carry == $past(in_carry)));

    // R3: logical shifts past the width clear everything
    a_r3_far_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_kind == 2'd0 || in_kind == 2'd1) && in_amt > AMT_W'(W)) |=>
            (out_data == '0 && !out_carry));

    // R5: arithmetic right at or past the width replicates the sign
    a_r5_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd2 && in_amt >= AMT_W'(W)) |=>
            (out_data == {W{$past(in_data[W-1])}} && out_carry == $past(in_data[W-1])));

    // R6: rotate by a non-zero multiple of the width keeps data, carry from bit W-1
    a_r6_ror_multiple: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd3 && in_amt != '0 && in_amt[RW-1:0] == '0) |=>
            (out_data == $past(in_data) && out_carry == $past(in_data[W-1])));

    // R7: rotation preserves the number of set bits
    a_r7_ror_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd3) |=>
            ($countones(out_data) == $countones($past(in_data))));
endmodule

// File: tb/regshift_unit_tb.sv
`timescale 1ns/1ps
module regshift_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [7:0]  in_amt = '0;
    logic [1:0]  in_kind = '0;
    logic        in_carry = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_carry;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    regshift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_amt(in_amt), .in_kind(in_kind), .in_carry(in_carry),
        .out_valid(out_valid), .out_data(out_data), .out_carry(out_carry)
    );

    // Per-bit reference built from the requirements; returns {carry, result}.
    function automatic logic [32:0] model(logic [31:0] d, int a, int k, logic c);
        logic [31:0] r;
        logic        co;
        int          rr;
        r  = '0;
        co = 1'b0;
        if (a == 0) return {c, d};
        case (k)
            0: begin
                for (int i = 0; i < 32; i++) r[i] = (i >= a) ? d[i-a] : 1'b0;
                co = (a <= 32) ? d[32-a] : 1'b0;
            end
            1: begin
                for (int i = 0; i < 32; i++) r[i] = (i + a < 32) ? d[i+a] : 1'b0;
                co = (a <= 32) ? d[a-1] : 1'b0;
            end
            2: begin
                for (int i = 0; i < 32; i++) r[i] = (i + a < 32) ? d[i+a] : d[31];
                co = (a <= 32) ? d[a-1] : d[31];
            end
            default: begin
                rr = a % 32;
                for (int i = 0; i < 32; i++) r[i] = d[(i + rr) % 32];
                co = (rr == 0) ? d[31] : d[rr-1];
            end
        endcase
        return {co, r};
    endfunction

    function automatic string tag(int a, int k);
        if (a == 0) return "R1";
        case (k)
            0: return (a < 32) ? "R2" : "R3";
            1: return (a <= 32) ? "R4" : "R3";
            2: return "R5";
            default: return (a % 32 == 0) ? "R6" : "R7";
        endcase
    endfunction

    task automatic check(string req, logic [32:0] act, logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] d, int a, int k, logic c);
        logic [32:0] e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_amt   = 8'(a);
        in_kind  = 2'(k);
        in_carry = c;
        e = model(d, a, k, c);
        @(negedge clk);
        check("R8", {32'd0, out_valid}, {32'd0, 1'b1});
        check(tag(a, k), {out_carry, out_data}, e);
    endtask

    initial begin
        logic [31:0] pats [5];
        logic [32:0] last;
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hA5C3_5A3C;
        pats[3] = 32'hFFFF_FFFF;
        pats[4] = 32'h1234_8765;

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10", {out_carry, out_data}, 33'd0);
        check("R10", {32'd0, out_valid}, 33'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {out_valid, out_carry, out_data[30:0]}, 33'd0);

        // Exhaustive amount sweep for every kind and pattern
        for (int p = 0; p < 5; p++)
            for (int k = 0; k < 4; k++)
                for (int a = 0; a < 256; a++)
                    apply(pats[p], a, k, 1'((a + p + k) & 1));

        // R9: hold while in_valid is low and operands change
        apply(32'hC001_0F0F, 4, 1, 1'b0);
        last = model(32'hC001_0F0F, 4, 1, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 32'hFFFF_0000;
        in_amt   = 8'd0;
        in_kind  = 2'd3;
        in_carry = 1'b1;
        @(negedge clk);
        check("R9", {32'd0, out_valid}, 33'd0);
        check("R9", {out_carry, out_data}, last);
        @(negedge clk);
        check("R9", {out_carry, out_data}, last);

        // R8: back-to-back valid inputs after an idle gap
        apply(32'h0000_0003, 31, 0, 1'b0);
        apply(32'h8000_0000, 32, 2, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule